// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs Clause 22 management frames on the two-wire bus that links a MAC to its PHYs. From the system clock it makes the management clock (MDC), using a programmable divider. It shifts each 64-bit frame onto a tri-state data line, which is split here into `mdio_o`, `mdio_oe` and `mdio_i`. Each bit takes two half-periods of MDC. The block changes the line on a falling MDC edge and samples it on a rising edge. On a read it releases the line from the turnaround field onward. It then takes the PHY's turnaround zero and 16 data bits, most significant bit first.

The host issues a command on a valid/ready handshake. `cmd_valid` carries the command, and ready is the inverse of `busy`. A command is taken in any cycle where `cmd_valid` is high and `busy` is low. A command presented while `busy` is high is dropped rather than held, so the host must keep `cmd_valid` high until it sees `busy` rise. The result leaves on a one-cycle `rsp_valid` strobe with no back-pressure. `rsp_data` and `rsp_noack` hold their values until the next command is accepted. MDC stays low whenever no frame is running.

Top module: `mgmt_master`

## Requirements
- R1: While reset is held, `mdc`, `mdio_oe`, `busy` and `rsp_valid` are all 0.
- R2: During a frame, each bit period is `DIV_HALF` clocks of `mdc` low followed by `DIV_HALF` clocks of `mdc` high. The first low half starts in the cycle after the command is accepted. `mdc` is 0 outside a frame.
- R3: Frame bits 0 to 31 (bit 0 is sent first) are a preamble of ones, driven with `mdio_oe`=1.
- R4: Bits 32 and 33 are the start code, 0 then 1. Bits 34 and 35 are the operation code: 1,0 for a read (`cmd_rd`=1) and 0,1 for a write.
- R5: Bits 36 to 40 carry `cmd_phy` and bits 41 to 45 carry `cmd_reg`, each sent most significant bit first and driven by the master.
- R6: On a read, `mdio_oe` is 0 from bit 46 to the end of the frame. `mdio_i` is sampled at each rising `mdc`. The samples taken during bits 48 to 63 form `rsp_data`, first sample in bit 15. The line stays released after the frame.
- R7: On a write, the master drives all 64 bits: bits 46 and 47 are 1 then 0, and bits 48 to 63 are `cmd_wdata` most significant bit first. `rsp_data` reads 0 when the write completes.
- R8: `rsp_noack` is 1 at the end of a read exactly when the bit sampled in bit 47 was 1. It is always 0 after a write.
- R9: `busy` rises in the cycle after a command is accepted and stays high through the last high half of bit 63. In the next cycle, `busy` falls and `rsp_valid` pulses for exactly one cycle. A new command may be accepted in that same cycle.
- R10: A command presented while `busy` is high has no effect: the running frame is unchanged and no further frame follows it.
- R11: `mdio_o` and `mdio_oe` change only at the clock edge where `mdc` falls (or a frame starts). They stay constant while `mdc` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request; accepted when `busy` is 0 |
| cmd_rd | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Write payload |
| busy | output | 1 | Frame in progress (inverse of command ready) |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | 16 | Read payload, held until the next command |
| rsp_noack | output | 1 | Read turnaround bit was not 0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
The bench attacks the points where the master hands the line over. A design that released the line one bit late, or kept driving through the read payload, would show `mdio_oe` wrong at bit 46 or beyond. A design that sampled on the falling edge, or started capture at bit 47, would return a read word shifted by one bit.

It sends a second command in the very cycle of the completion strobe. A design that dropped that command, or lost a clock there, would show up in the next frame's timing. Commands sent in the middle of a frame catch a design that reloads its shifter or queues a phantom frame. A read with no PHY present catches a turnaround check that looks at the wrong bit. Write frames with all-ones and all-zeros payloads catch an operation code or turnaround pattern that is swapped or reversed.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int BIT_W      = $clog2(FRAME_LEN);
  // bit index of the first turnaround bit: preamble, start, opcode, two addresses
  localparam int TA_FIRST   = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int TA_SECOND  = TA_FIRST + 1;
  localparam int DATA_FIRST = TA_FIRST + 2;

  typedef logic [BIT_W-1:0] bitpos_t;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic [DATA_W-1:0] wdata;
  } mgmt_cmd_t;

  // Whole frame, first bit to send in the top position.
  function automatic logic [FRAME_LEN-1:0] build_frame(mgmt_cmd_t c);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] pay;
    op  = c.rd ? 2'b10 : 2'b01;
    ta  = c.rd ? 2'b11 : 2'b10;
    pay = c.rd ? '1 : c.wdata;
    return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regn, ta, pay};
  endfunction
endpackage

// File: rtl/mgmt_clkgen.sv
module mgmt_clkgen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int PERIOD = 2 * HALF;
  localparam int PH_W   = $clog2(PERIOD);
  localparam logic [PH_W-1:0] RISE_AT = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] FALL_AT = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph;

  assign rise_stb = run && (ph == RISE_AT);
  assign fall_stb = run && (ph == FALL_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      ph  <= '0;
      mdc <= 1'b0;
    end else if (fall_stb) begin
      ph  <= '0;
      mdc <= 1'b0;
    end else begin
      ph <= ph + 1'b1;
      if (rise_stb) mdc <= 1'b1;
    end
  end

  assert_mdc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc);
  assert_mdc_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);
  assert_mdc_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !mdc);
endmodule

// File: rtl/mgmt_framer.sv
module mgmt_framer
  import mgmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  mgmt_cmd_t cmd,
  input  logic      fall_stb,
  input  logic      active,
  input  logic      mdc,
  output logic      mdio_o,
  output logic      mdio_oe,
  output logic      frame_rd,
  output bitpos_t   bitn,
  output logic      last_bit
);
  localparam bitpos_t LAST_POS = bitpos_t'(FRAME_LEN - 1);
  localparam bitpos_t REL_POS  = bitpos_t'(TA_FIRST);

  logic [FRAME_LEN-1:0] sh;
  bitpos_t              nxt;

  assign nxt      = bitn + 1'b1;
  assign last_bit = fall_stb && (bitn == LAST_POS);
  assign mdio_o   = sh[FRAME_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      bitn     <= '0;
      mdio_oe  <= 1'b0;
      frame_rd <= 1'b0;
    end else if (load) begin
      sh       <= build_frame(cmd);
      bitn     <= '0;
      mdio_oe  <= 1'b1;
      frame_rd <= cmd.rd;
    end else if (fall_stb) begin
      sh   <= {sh[FRAME_LEN-2:0], 1'b0};
      bitn <= nxt;
      if (last_bit)                        mdio_oe <= 1'b0;
      else if (frame_rd && nxt >= REL_POS) mdio_oe <= 1'b0;
    end
  end

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active && frame_rd && (bitn >= REL_POS) |-> !mdio_oe);
  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active && !frame_rd |-> mdio_oe);
  assert_stable_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));
  assert_hold_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && !$past(fall_stb) |-> $stable(sh));
endmodule

// File: rtl/mgmt_capture.sv
module mgmt_capture
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise_stb,
  input  logic              frame_rd,
  input  bitpos_t           bitn,
  input  logic              mdio_i,
  output logic [DATA_W-1:0] rdata,
  output logic              ta_bad
);
  localparam bitpos_t TA2_POS = bitpos_t'(TA_SECOND);
  localparam bitpos_t D0_POS  = bitpos_t'(DATA_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      ta_bad <= 1'b0;
    end else if (clear) begin
      rdata  <= '0;
      ta_bad <= 1'b0;
    end else if (rise_stb && frame_rd) begin
      if (bitn == TA2_POS) ta_bad <= mdio_i;
      if (bitn >= D0_POS)  rdata  <= {rdata[DATA_W-2:0], mdio_i};
    end
  end

  assert_ta_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !(rise_stb && bitn == TA2_POS) |=> $stable(ta_bad));
endmodule

// File: rtl/mgmt_master.sv
module mgmt_master
  import mgmt_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_noack,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic      accept;
  logic      rise_stb;
  logic      fall_stb;
  logic      last_bit;
  logic      frame_rd;
  bitpos_t   bitn;
  mgmt_cmd_t cmd;

  assign accept = cmd_valid && !busy;
  assign cmd    = '{rd: cmd_rd, phy: cmd_phy, regn: cmd_reg, wdata: cmd_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= last_bit;
      if (accept)        busy <= 1'b1;
      else if (last_bit) busy <= 1'b0;
    end
  end

  mgmt_clkgen #(.HALF(DIV_HALF)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mgmt_framer u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .cmd      (cmd),
    .fall_stb (fall_stb),
    .active   (busy),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .frame_rd (frame_rd),
    .bitn     (bitn),
    .last_bit (last_bit)
  );

  mgmt_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .rise_stb (rise_stb),
    .frame_rd (frame_rd),
    .bitn     (bitn),
    .mdio_i   (mdio_i),
    .rdata    (rsp_data),
    .ta_bad   (rsp_noack)
  );

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
  assert_write_noack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !frame_rd |-> !rsp_noack);
  assert_idle_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/tb_mgmt_master.sv
`timescale 1ns/1ps
module tb_mgmt_master;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_rd = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, rsp_valid, rsp_noack, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rsp_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int q[$];
  bit pend_done = 0;
  logic [15:0] exp_data = '0;
  logic exp_noack = 1'b0;
  logic cur_rd = 1'b0;
  logic phy_drv = 1'b1;
  logic [15:0] phy_data = '0;
  logic phy_ack = 1'b1;

  always #2.5 clk = ~clk;

  // bus line: master drive wins, otherwise PHY drive or pull-up
  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mgmt_master #(.DIV_HALF(H)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_noack(rsp_noack), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: expand a command into one expected entry per system clock.
  task automatic enqueue(input logic rd, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd);
    bit fb[$];
    for (int i = 0; i < 32; i++) fb.push_back(1'b1);
    fb.push_back(1'b0); fb.push_back(1'b1);
    fb.push_back(rd);   fb.push_back(!rd);
    for (int i = 4; i >= 0; i--) fb.push_back(phy[i]);
    for (int i = 4; i >= 0; i--) fb.push_back(rg[i]);
    if (rd) begin
      for (int i = 0; i < 18; i++) fb.push_back(1'b1);
    end else begin
      fb.push_back(1'b1); fb.push_back(1'b0);
      for (int i = 15; i >= 0; i--) fb.push_back(wd[i]);
    end
    for (int b = 0; b < 64; b++) begin
      int oe = (rd && b >= 46) ? 0 : 1;
      for (int c = 0; c < 2 * H; c++) begin
        int hi = (c >= H) ? 1 : 0;
        q.push_back(b * 8 + hi * 4 + oe * 2 + int'(fb[b]));
      end
    end
    pend_done = 1;
    cur_rd    = rd;
    exp_data  = rd ? phy_data : 16'h0000;
    exp_noack = rd && !phy_ack;
  endtask

  task automatic check_cycle();
    if (q.size() > 0) begin
      int e = q.pop_front();
      int b = e / 8;
      string t;
      if (b < 32)      t = "R3";
      else if (b < 36) t = "R4";
      else if (b < 46) t = "R5";
      else             t = cur_rd ? "R6" : "R7";
      chk(mdc == e[2], "R2 mdc", mdc, e[2]);
      chk(busy == 1'b1, "R9 busy", busy, 1);
      chk(mdio_oe == e[1], t, mdio_oe, e[1]);
      if (e[1] == 1'b1) chk(mdio_o == e[0], e[2] ? "R11" : t, mdio_o, e[0]);
      if (cur_rd && b == 47)      phy_drv = !phy_ack;
      else if (cur_rd && b >= 48) phy_drv = phy_data[63 - b];
      else                        phy_drv = 1'b1;
    end else if (pend_done) begin
      chk(rsp_valid == 1'b1, "R9 done", rsp_valid, 1);
      chk(busy == 1'b0, "R9 busy drop", busy, 0);
      chk(rsp_data == exp_data, cur_rd ? "R6 data" : "R7 data", rsp_data, exp_data);
      chk(rsp_noack == exp_noack, "R8 noack", rsp_noack, exp_noack);
      chk(mdio_oe == 1'b0, "R6 release", mdio_oe, 0);
      pend_done = 0;
      phy_drv   = 1'b1;
    end else begin
      chk(rsp_valid == 1'b0, "R9 idle strobe", rsp_valid, 0);
      chk(busy == 1'b0, "R10 idle busy", busy, 0);
      chk(mdc == 1'b0, "R2 idle mdc", mdc, 0);
      chk(mdio_oe == 1'b0, "R6 idle oe", mdio_oe, 0);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_cycle();
  endtask

  task automatic send(input logic rd, input logic [4:0] phy,
                      input logic [4:0] rg, input logic [15:0] wd);
    cmd_rd = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    cmd_valid = 1'b1;
    if (!busy) enqueue(rd, phy, rg, wd);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (q.size() > 0 || pend_done) tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 line", {mdc, mdio_oe}, 0);
      chk(busy == 1'b0 && rsp_valid == 1'b0, "R1 status", {busy, rsp_valid}, 0);
    end
    rst_n = 1'b1;
    repeat (3) tick();

    // R6 read with answering PHY
    phy_data = 16'hA5C3; phy_ack = 1'b1;
    send(1'b1, 5'd5, 5'd2, 16'h0000);
    wait_done();

    // R7 write issued back-to-back in the strobe cycle (R9), then R10 ignored commands
    send(1'b0, 5'd31, 5'd16, 16'h8001);
    repeat (40) tick();
    send(1'b1, 5'd3, 5'd3, 16'h1234);
    repeat (100) tick();
    send(1'b0, 5'd1, 5'd1, 16'hFFFF);
    wait_done();
    repeat (4) tick();

    // R8 read with no PHY present
    phy_data = 16'hFFFF; phy_ack = 1'b0;
    send(1'b1, 5'd0, 5'd31, 16'h0000);
    wait_done();
    tick();

    // R5 address bit order, R6 single low-order data bit
    phy_data = 16'h0001; phy_ack = 1'b1;
    send(1'b1, 5'd16, 5'd1, 16'h0000);
    wait_done();

    // R7 all-ones and all-zero payloads, back-to-back
    send(1'b0, 5'd0, 5'd0, 16'hFFFF);
    wait_done();
    send(1'b0, 5'd10, 5'd21, 16'h0000);
    wait_done();
    repeat (5) tick();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finish_run();
  end
endmodule